// File: doc/BRIEF.md
# Size-Aware Compare Flag Generator

This block turns the operands and result of a compare operation into a packed condition word. The operand size can be 8, 16 or 32 bits. It masks the operands and the result to the selected width. From those it forms four raw flags: zero, sign, overflow and carry. It then derives three ordering flags from the raw ones: unsigned-above, signed-greater and signed-greater-or-equal. The word written to the destination register carries these seven flags in its low bits and zeros above them.

A second path judges a conditional transfer. It picks one of three condition registers and one bit position within it, and compares that bit with an expected value. A select code of 3 means the transfer is always taken.

Both results are registered, so they appear one clock after the inputs are applied. The ALU result is computed outside this block and arrives on `res_i`.

Top module: `cmp_flag_unit`

## Requirements
- R1: `size_i` picks the flag width: 0 selects the low 8 bits (top bit 7), 1 selects the low 16 bits (top bit 15), and 2 or 3 select the full 32 bits (top bit 31). Bits above the selected width have no effect on any flag.
- R2: The zero flag (word bit 0) is 1 exactly when the result, masked to the selected width, is 0.
- R3: The sign flag (word bit 3) equals the result bit at the top position of the selected width.
- R4: The overflow flag (word bit 2) is 1 when the sign differs from A's top bit and A's top bit differs from B's top bit.
- R5: For `op_i` = 0 (add), the carry flag (word bit 1) is bit `width` of the sum of masked A and masked B.
- R6: For `op_i` = 2 (subtract), the carry flag is bit `width` of masked A minus masked B, taken as a 33-bit two's-complement value.
- R7: For any `op_i` other than 0 or 2, the carry flag is 0.
- R8: The derived flags are set as follows. Above (bit 6) = NOT carry AND NOT zero. Greater (bit 5) = (sign == overflow) AND NOT zero. Greater-or-equal (bit 4) = (sign == overflow).
- R9: Bits 31:7 of `flags_o` are always 0.
- R10: When `cond_sel_i` = 3, `take_o` is 1 regardless of the condition registers.
- R11: When `cond_sel_i` is 0, 1 or 2, `take_o` is 1 exactly when bit `cond_bit_i` of condition register `cond_sel_i` equals `cond_exp_i`. Register n occupies bits `32*n+31 : 32*n` of `cond_regs_i`.
- R12: Both outputs are registered with one cycle of latency. While `rst_ni` is low they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_i | input | 32 | ALU result of the operation |
| op_i | input | 4 | Operation code: 0 add, 2 subtract, others no carry |
| size_i | input | 2 | Width code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| cond_regs_i | input | 96 | Three condition registers, register 0 in the low bits |
| cond_sel_i | input | 2 | Condition register select; 3 = always |
| cond_bit_i | input | 5 | Bit position to test |
| cond_exp_i | input | 1 | Expected value of the tested bit |
| flags_o | output | 32 | Packed condition word |
| take_o | output | 1 | Transfer taken |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 4-bit operation code, add on code 0 and subtract on code 1's neighbour 2. With these defaults all three width codes, as well as the spare code 3, map onto real masks. The carry position therefore lands on bits 8, 16 and 32 in turn, and the 33-bit borrow of a full-width subtract is exercised. Stray bits above the active width are applied on purpose, to show they do not leak into the flags.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
  localparam int unsigned FLAG_W  = 7;
  localparam int unsigned FB_ZERO = 0;
  localparam int unsigned FB_CARRY = 1;
  localparam int unsigned FB_OVF  = 2;
  localparam int unsigned FB_SIGN = 3;
  localparam int unsigned FB_GE   = 4;
  localparam int unsigned FB_GT   = 5;
  localparam int unsigned FB_ABOVE = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
    logic carry;
  } raw_flags_t;
endpackage

// File: rtl/cmp_width_sel.sv
module cmp_width_sel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] a_m_o,
  output logic [DATA_W-1:0] b_m_o,
  output logic [DATA_W-1:0] res_m_o,
  output logic              a_top_o,
  output logic              b_top_o,
  output logic              res_top_o,
  output logic [$clog2(DATA_W+1)-1:0] width_o
);
  import cmp_flag_pkg::*;

  localparam int unsigned WW = $clog2(DATA_W+1);

  logic [DATA_W-1:0] mask;
  int unsigned       top;

  always_comb begin
    case (size_e'(size_i))
      SZ_BYTE: begin mask = DATA_W'({8{1'b1}});  width_o = WW'(8);  end
      SZ_HALF: begin mask = DATA_W'({16{1'b1}}); width_o = WW'(16); end
      default: begin mask = '1;                  width_o = WW'(DATA_W); end
    endcase
    top       = int'(width_o) - 1;
    a_m_o     = a_i & mask;
    b_m_o     = b_i & mask;
    res_m_o   = res_i & mask;
    a_top_o   = a_i[top];
    b_top_o   = b_i[top];
    res_top_o = res_i[top];
  end
endmodule

// File: rtl/cmp_flag_core.sv
module cmp_flag_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4,
  parameter logic [OP_W-1:0] OP_ADD = 4'd0,
  parameter logic [OP_W-1:0] OP_SUB = 4'd2
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_m_i,
  input  logic [DATA_W-1:0] b_m_i,
  input  logic [DATA_W-1:0] res_m_i,
  input  logic              a_top_i,
  input  logic              b_top_i,
  input  logic              res_top_i,
  input  logic [$clog2(DATA_W+1)-1:0] width_i,
  output logic [cmp_flag_pkg::FLAG_W-1:0] flags_o
);
  import cmp_flag_pkg::*;

  localparam int unsigned XW = DATA_W + 1;

  raw_flags_t    raw;
  logic [XW-1:0] ext_sum;
  logic [XW-1:0] ext_dif;

  always_comb begin
    ext_sum   = {1'b0, a_m_i} + {1'b0, b_m_i};
    ext_dif   = {1'b0, a_m_i} - {1'b0, b_m_i};
    raw.zero  = (res_m_i == '0);
    raw.sign  = res_top_i;
    raw.ovf   = (res_top_i != a_top_i) && (a_top_i != b_top_i);
    if (op_i == OP_ADD)      raw.carry = ext_sum[width_i];
    else if (op_i == OP_SUB) raw.carry = ext_dif[width_i];
    else                     raw.carry = 1'b0;

    flags_o           = '0;
    flags_o[FB_ZERO]  = raw.zero;
    flags_o[FB_CARRY] = raw.carry;
    flags_o[FB_OVF]   = raw.ovf;
    flags_o[FB_SIGN]  = raw.sign;
    flags_o[FB_GE]    = (raw.sign == raw.ovf);
    flags_o[FB_GT]    = (raw.sign == raw.ovf) && !raw.zero;
    flags_o[FB_ABOVE] = !raw.carry && !raw.zero;
  end
endmodule

// File: rtl/cmp_branch_eval.sv
module cmp_branch_eval #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_CREG  = 3
) (
  input  logic [N_CREG*DATA_W-1:0]   cond_regs_i,
  input  logic [1:0]                 cond_sel_i,
  input  logic [$clog2(DATA_W)-1:0]  cond_bit_i,
  input  logic                       cond_exp_i,
  output logic                       take_o
);
  localparam logic [1:0] SEL_ALWAYS = 2'd3;

  logic [DATA_W-1:0] regs [N_CREG];

  for (genvar g = 0; g < N_CREG; g++) begin : g_split
    assign regs[g] = cond_regs_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    take_o = 1'b0;
    if (cond_sel_i == SEL_ALWAYS) take_o = 1'b1;
    else begin
      for (int i = 0; i < N_CREG; i++)
        if (int'(cond_sel_i) == i) take_o = (regs[i][cond_bit_i] == cond_exp_i);
    end
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned N_CREG = 3,
  parameter logic [OP_W-1:0] OP_ADD = 4'd0,
  parameter logic [OP_W-1:0] OP_SUB = 4'd2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DATA_W-1:0]           a_i,
  input  logic [DATA_W-1:0]           b_i,
  input  logic [DATA_W-1:0]           res_i,
  input  logic [OP_W-1:0]             op_i,
  input  logic [1:0]                  size_i,
  input  logic [N_CREG*DATA_W-1:0]    cond_regs_i,
  input  logic [1:0]                  cond_sel_i,
  input  logic [$clog2(DATA_W)-1:0]   cond_bit_i,
  input  logic                        cond_exp_i,
  output logic [DATA_W-1:0]           flags_o,
  output logic                        take_o
);
  import cmp_flag_pkg::*;

  localparam int unsigned WW = $clog2(DATA_W+1);

  logic [DATA_W-1:0] a_m, b_m, res_m;
  logic              a_top, b_top, res_top;
  logic [WW-1:0]     width;
  logic [FLAG_W-1:0] flags_d;
  logic              take_d;

  cmp_width_sel #(.DATA_W(DATA_W)) u_width (
    .size_i(size_i), .a_i(a_i), .b_i(b_i), .res_i(res_i),
    .a_m_o(a_m), .b_m_o(b_m), .res_m_o(res_m),
    .a_top_o(a_top), .b_top_o(b_top), .res_top_o(res_top),
    .width_o(width)
  );

  cmp_flag_core #(.DATA_W(DATA_W), .OP_W(OP_W), .OP_ADD(OP_ADD), .OP_SUB(OP_SUB)) u_core (
    .op_i(op_i), .a_m_i(a_m), .b_m_i(b_m), .res_m_i(res_m),
    .a_top_i(a_top), .b_top_i(b_top), .res_top_i(res_top),
    .width_i(width), .flags_o(flags_d)
  );

  cmp_branch_eval #(.DATA_W(DATA_W), .N_CREG(N_CREG)) u_branch (
    .cond_regs_i(cond_regs_i), .cond_sel_i(cond_sel_i),
    .cond_bit_i(cond_bit_i), .cond_exp_i(cond_exp_i), .take_o(take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      take_o  <= 1'b0;
    end else begin
      flags_o <= DATA_W'(flags_d);
      take_o  <= take_d;
    end
  end

  AST_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[DATA_W-1:FLAG_W] == '0); // R9
  AST_ZERO_BLOCKS_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FB_ZERO] |-> !flags_o[FB_ABOVE] && !flags_o[FB_GT]); // R8
  AST_GT_IMPLIES_GE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FB_GT] |-> flags_o[FB_GE]); // R8
  AST_NO_CARRY_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_ADD && op_i != OP_SUB) |=> !flags_o[FB_CARRY]); // R7
  AST_ALWAYS_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 2'd3) |=> take_o); // R10
  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_i == '0) |=> flags_o[FB_ZERO]); // R2
endmodule

// File: tb/tb_cmp_flag_unit.sv
module tb_cmp_flag_unit;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, res_i = '0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [95:0] cond_regs_i = '0;
  logic [1:0]  cond_sel_i = '0;
  logic [4:0]  cond_bit_i = '0;
  logic        cond_exp_i = 1'b0;
  logic [31:0] flags_o;
  logic        take_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cmp_flag_unit dut (.*);

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic [3:0] op, input logic [1:0] sz);
    int w;
    logic [32:0] am, bm, rm, ex;
    logic z, s, o, c, at, bt;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    am = {1'b0, a}; bm = {1'b0, b}; rm = {1'b0, r};
    for (int i = w; i < 33; i++) begin am[i] = 1'b0; bm[i] = 1'b0; rm[i] = 1'b0; end
    z  = (rm == 0);
    s  = r[w-1]; at = a[w-1]; bt = b[w-1];
    o  = (s != at) && (at != bt);
    if (op == 4'd0)      begin ex = am + bm; c = ex[w]; end
    else if (op == 4'd2) begin ex = am - bm; c = ex[w]; end
    else c = 1'b0;
    return {25'd0, ~c & ~z, (s == o) & ~z, s == o, s, o, c, z};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_cmp(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic [3:0] op, input logic [1:0] sz);
    @(negedge clk_i);
    a_i = a; b_i = b; res_i = r; op_i = op; size_i = sz;
    @(posedge clk_i); #1;
  endtask

  task automatic cmp_case(input string req, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic [3:0] op, input logic [1:0] sz);
    apply_cmp(a, b, r, op, sz);
    check(req, flags_o, model(a, b, r, op, sz));
  endtask

  task automatic t_reset;
    check("R12 flags reset", flags_o, 32'h0);
    check("R12 take reset", {31'd0, take_o}, 32'h0);
  endtask

  task automatic t_literal;
    apply_cmp(32'h5, 32'h5, 32'h0, 4'd2, 2'd0);
    check("R8 R2 equal sub", flags_o, 32'h11);
    apply_cmp(32'h3, 32'h5, 32'hFE, 4'd2, 2'd0);
    check("R6 R3 borrow", flags_o, 32'h0A);
  endtask

  task automatic t_sizes;
    cmp_case("R1 byte upper junk", 32'hABCD_1200, 32'h5555_1200, 32'hFFFF_FF00, 4'd2, 2'd0);
    cmp_case("R1 half", 32'h0001_8000, 32'h0000_7FFF, 32'h0001_0001, 4'd2, 2'd1);
    cmp_case("R1 word", 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 4'd2, 2'd2);
    cmp_case("R1 code3 wide", 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 4'd2, 2'd3);
    apply_cmp(32'h0, 32'h0, 32'h0000_0100, 4'd1, 2'd0);
    check("R1 R2 byte masks zero", flags_o & 32'h1, 32'h1);
  endtask

  task automatic t_add;
    cmp_case("R5 byte carry", 32'hF0, 32'h20, 32'h10, 4'd0, 2'd0);
    cmp_case("R5 half carry", 32'hFFFF, 32'h1, 32'h0, 4'd0, 2'd1);
    cmp_case("R5 word carry", 32'hFFFF_FFFF, 32'h2, 32'h1, 4'd0, 2'd2);
    cmp_case("R4 ovf", 32'h7F, 32'h80, 32'hFF, 4'd0, 2'd0);
  endtask

  task automatic t_sub;
    cmp_case("R6 word borrow", 32'h1, 32'h2, 32'hFFFF_FFFF, 4'd2, 2'd2);
    cmp_case("R4 R6 sub ovf", 32'h80, 32'h01, 32'h7F, 4'd2, 2'd0);
    cmp_case("R8 greater", 32'h10, 32'h3, 32'hD, 4'd2, 2'd1);
  endtask

  task automatic t_other;
    apply_cmp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 4'd4, 2'd2);
    check("R7 no carry and-op", flags_o & 32'h2, 32'h0);
    cmp_case("R7 xor op", 32'h80, 32'h7F, 32'hFF, 4'd6, 2'd0);
    check("R9 upper zero", flags_o & 32'hFFFF_FF80, 32'h0);
  endtask

  task automatic t_branch;
    @(negedge clk_i);
    cond_regs_i = {32'h0000_0000, 32'h0000_0010, 32'h8000_0000};
    cond_sel_i = 2'd3; cond_bit_i = 5'd0; cond_exp_i = 1'b1;
    @(posedge clk_i); #1;
    check("R10 always", {31'd0, take_o}, 32'h1);
    @(negedge clk_i); cond_sel_i = 2'd0; cond_bit_i = 5'd31; cond_exp_i = 1'b1;
    @(posedge clk_i); #1;
    check("R11 reg0 bit31 match", {31'd0, take_o}, 32'h1);
    @(negedge clk_i); cond_sel_i = 2'd1; cond_bit_i = 5'd4; cond_exp_i = 1'b0;
    @(posedge clk_i); #1;
    check("R11 reg1 bit4 mismatch", {31'd0, take_o}, 32'h0);
    @(negedge clk_i); cond_sel_i = 2'd2; cond_bit_i = 5'd4; cond_exp_i = 1'b0;
    @(posedge clk_i); #1;
    check("R11 reg2 bit4 match zero", {31'd0, take_o}, 32'h1);
  endtask

  initial begin : watchdog
    #(CLK_P * 5000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1);
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_literal();
    t_sizes();
    t_add();
    t_sub();
    t_other();
    t_branch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule